// File: doc/BRIEF.md
# Reduced-MII Receive Framer (MAC side)

This block is the receive front end of an Ethernet MAC attached to a PHY over the reduced media-independent interface at 100 Mbps. On every rising edge of the 50 MHz reference clock it samples the carrier/data-valid line, the two receive data bits and the receive-error line. The carrier line can rise at any moment relative to the clock, so it passes through a synchronizer. The data and error lines are delayed by the same number of stages so that all three stay aligned.

A small state machine drops the zero di-bits the PHY sends while it is still decoding. It then follows the preamble until the start-of-frame pattern appears and packs the payload di-bits into bytes, least significant bits first. Each byte leaves on a valid/data/last/error stream. One completed byte is held back, so that the byte in progress when carrier drops can be marked as the last one. The block also raises a collision flag whenever the local transmitter is enabled while synchronized carrier is present.

States: `ST_IDLE` (no frame; zero di-bits with carrier are skipped here), `ST_PREAMBLE` (preamble di-bits being seen), `ST_PAYLOAD` (bytes being packed), `ST_DISCARD` (a malformed frame being ignored until carrier drops). Transitions: IDLE→PREAMBLE on carrier with di-bit `01`; IDLE→DISCARD on carrier with `10` or `11`; PREAMBLE→PAYLOAD on di-bit `11`; PREAMBLE→DISCARD on `00` or `10`; PREAMBLE, PAYLOAD or DISCARD→IDLE when synchronized carrier is low; every other case stays in the current state.

Top module: `rmii_rx_mac`

## Requirements
- R1: `crs_dv` goes through a two-stage synchronizer. `rxd` and `rx_er` are delayed by two stages as well. With `tx_en` high, `collision` is still low one clock edge after `crs_dv` rises and is high after the second edge.
- R2: Di-bits `00` received with carrier before any preamble di-bit are dropped and never produce output bytes.
- R3: Payload starts only after one or more `01` di-bits followed by a `11` di-bit. Any other non-zero di-bit before that point (for example `10`, or `11` with no preceding `01`) discards the whole frame, and no byte is output for it.
- R4: Every four payload di-bits form one byte. The first di-bit received lands in bits [1:0] and the fourth lands in bits [7:6].
- R5: Each byte is presented for exactly one cycle with `out_valid` high. `out_last` is high only on the final whole byte of a frame, and `out_valid` is low in the cycle after `out_last`.
- R6: If `rx_er` is high with carrier during any payload di-bit, `out_err` is high on that frame's last byte. `out_err` is low on every byte that is not last.
- R7: While synchronized carrier is low, `rxd` and `rx_er` have no effect: no bytes are emitted, and the next frame's data and error flag are unaffected. `rx_er` seen before the start-of-frame di-bit is cleared when that di-bit arrives.
- R8: If carrier drops after 1 to 3 di-bits of an unfinished byte, that partial byte is dropped and `out_err` is set on the last whole byte.
- R9: `collision` is high exactly when `tx_en` is high and synchronized carrier is high.
- R10: A frame that ends before one whole payload byte is assembled produces no output at all.
- R11: During and right after reset, `out_valid`, `out_last`, `out_err` and `collision` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crs_dv | input | 1 | Carrier sense / receive data valid from the PHY (asynchronous rise) |
| rxd | input | 2 | Receive di-bit from the PHY |
| rx_er | input | 1 | Receive symbol error from the PHY |
| tx_en | input | 1 | Local transmitter enable |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Received byte |
| out_last | output | 1 | Marks the final byte of a frame |
| out_err | output | 1 | Frame errored (on the last byte only) |
| collision | output | 1 | Transmit enable while carrier is present |

## Verification
The bench sweeps frame shape: 0 to 3 leading zero di-bits, preamble lengths of 1 to 7, and 1 to 5 payload bytes with values computed from a seed. These patterns separate correct zero skipping, start-of-frame detection and least-significant-first packing from off-by-one-di-bit or bit-order faults. An error pulse is moved across every payload di-bit position, and truncations of 1 to 3 di-bits are run with 0 to 2 whole bytes. Together these show whether error accumulation, partial-byte dropping and the empty-frame rule work at byte boundaries. Malformed preambles, noise on `rxd`/`rx_er` without carrier, an error pulse inside the preamble, and a carrier/transmit overlap cover frame discard, masking, error clearing and collision latency.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_PAYLOAD  = 2'd2,
        ST_DISCARD  = 2'd3
    } rx_state_e;

    localparam logic [1:0] DIBIT_QUIET = 2'b00;
    localparam logic [1:0] DIBIT_PRE   = 2'b01;
    localparam logic [1:0] DIBIT_SFD   = 2'b11;

endpackage

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync #(
    parameter int STAGES  = 2,
    parameter int DIBIT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               crs_in,
    input  logic [DIBIT_W-1:0] rxd_in,
    input  logic               er_in,
    output logic               crs_s,
    output logic [DIBIT_W-1:0] rxd_s,
    output logic               er_s
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0]  crs_q;
    logic [STAGES-1:0]  er_q;
    logic [DIBIT_W-1:0] rxd_q [STAGES];

    // Carrier is resynchronized; data and error ride an equal-length pipe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crs_q <= '0;
            er_q  <= '0;
            for (int i = 0; i < STAGES; i++) begin
                rxd_q[i] <= '0;
            end
        end else begin
            crs_q[0] <= crs_in;
            er_q[0]  <= er_in;
            rxd_q[0] <= rxd_in;
            for (int i = 1; i < STAGES; i++) begin
                crs_q[i] <= crs_q[i-1];
                er_q[i]  <= er_q[i-1];
                rxd_q[i] <= rxd_q[i-1];
            end
        end
    end

    assign crs_s = crs_q[LAST];
    assign er_s  = er_q[LAST];
    assign rxd_s = rxd_q[LAST];

endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer #(
    parameter int BYTE_W  = 8,
    parameter int DIBIT_W = 2,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic [DIBIT_W-1:0] dibit,
    output logic [BYTE_W-1:0]  byte_out,
    output logic [CNT_W-1:0]   fill,
    output logic               full
);

    localparam int HOLD_W = BYTE_W - DIBIT_W;
    localparam int PER_BYTE = BYTE_W / DIBIT_W;
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(PER_BYTE - 1);

    logic [HOLD_W-1:0] hold_q;
    logic [CNT_W-1:0]  fill_q;

    // Newest di-bit enters at the top, so the first one ends in the LSBs
    assign byte_out = {dibit, hold_q};
    assign full     = shift && (fill_q == FILL_LAST);
    assign fill     = fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            fill_q <= '0;
        end else if (clear) begin
            hold_q <= '0;
            fill_q <= '0;
        end else if (shift) begin
            hold_q <= byte_out[BYTE_W-1:DIBIT_W];
            fill_q <= full ? '0 : fill_q + 1'b1;
        end
    end

endmodule

// File: rtl/rmii_rx_fsm.sv
module rmii_rx_fsm
    import rmii_rx_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DIBIT_W = 2,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               crs,
    input  logic [DIBIT_W-1:0] rxd,
    input  logic               er,
    input  logic [BYTE_W-1:0]  pk_byte,
    input  logic [CNT_W-1:0]   pk_fill,
    input  logic               pk_full,
    output logic               pk_clear,
    output logic               pk_shift,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_data,
    output logic               out_last,
    output logic               out_err
);

    rx_state_e state_q, state_d;

    logic              err_acc_q;
    logic              pend_v_q;
    logic [BYTE_W-1:0] pend_q;
    logic              sfd_hit;

    assign sfd_hit  = (state_q == ST_PREAMBLE) && crs && (rxd == DIBIT_SFD);
    assign pk_shift = (state_q == ST_PAYLOAD) && crs;
    assign pk_clear = (state_q != ST_PAYLOAD);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (crs) begin
                    if (rxd == DIBIT_PRE) begin
                        state_d = ST_PREAMBLE;
                    end else if (rxd != DIBIT_QUIET) begin
                        state_d = ST_DISCARD;
                    end
                end
            end
            ST_PREAMBLE: begin
                if (!crs) begin
                    state_d = ST_IDLE;
                end else if (rxd == DIBIT_SFD) begin
                    state_d = ST_PAYLOAD;
                end else if (rxd != DIBIT_PRE) begin
                    state_d = ST_DISCARD;
                end
            end
            ST_PAYLOAD: begin
                if (!crs) begin
                    state_d = ST_IDLE;
                end
            end
            ST_DISCARD: begin
                if (!crs) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
            err_acc_q <= 1'b0;
            pend_v_q  <= 1'b0;
            pend_q    <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
            if (sfd_hit) begin
                err_acc_q <= 1'b0;
                pend_v_q  <= 1'b0;
            end
            if (state_q == ST_PAYLOAD) begin
                if (crs) begin
                    err_acc_q <= err_acc_q | er;
                    if (pk_full) begin
                        pend_q   <= pk_byte;
                        pend_v_q <= 1'b1;
                        if (pend_v_q) begin
                            out_valid <= 1'b1;
                            out_data  <= pend_q;
                        end
                    end
                end else begin
                    pend_v_q <= 1'b0;
                    if (pend_v_q) begin
                        out_valid <= 1'b1;
                        out_data  <= pend_q;
                        out_last  <= 1'b1;
                        out_err   <= err_acc_q | (pk_fill != '0);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rmii_rx_mac.sv
module rmii_rx_mac #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int DIBIT_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               crs_dv,
    input  logic [DIBIT_W-1:0] rxd,
    input  logic               rx_er,
    input  logic               tx_en,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_data,
    output logic               out_last,
    output logic               out_err,
    output logic               collision
);

    localparam int PER_BYTE = BYTE_W / DIBIT_W;
    localparam int CNT_W    = (PER_BYTE > 1) ? $clog2(PER_BYTE) : 1;

    logic               crs_s;
    logic [DIBIT_W-1:0] rxd_s;
    logic               er_s;
    logic [BYTE_W-1:0]  pk_byte;
    logic [CNT_W-1:0]   pk_fill;
    logic               pk_full;
    logic               pk_clear;
    logic               pk_shift;

    rmii_rx_sync #(
        .STAGES  (SYNC_STAGES),
        .DIBIT_W (DIBIT_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .crs_in (crs_dv),
        .rxd_in (rxd),
        .er_in  (rx_er),
        .crs_s  (crs_s),
        .rxd_s  (rxd_s),
        .er_s   (er_s)
    );

    rmii_rx_packer #(
        .BYTE_W  (BYTE_W),
        .DIBIT_W (DIBIT_W),
        .CNT_W   (CNT_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pk_clear),
        .shift    (pk_shift),
        .dibit    (rxd_s),
        .byte_out (pk_byte),
        .fill     (pk_fill),
        .full     (pk_full)
    );

    rmii_rx_fsm #(
        .BYTE_W  (BYTE_W),
        .DIBIT_W (DIBIT_W),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .crs       (crs_s),
        .rxd       (rxd_s),
        .er        (er_s),
        .pk_byte   (pk_byte),
        .pk_fill   (pk_fill),
        .pk_full   (pk_full),
        .pk_clear  (pk_clear),
        .pk_shift  (pk_shift),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_err   (out_err)
    );

    assign collision = tx_en && crs_s;

endmodule

// File: rtl/rmii_rx_checker.sv
module rmii_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic crs_dv,
    input logic tx_en,
    input logic out_valid,
    input logic out_last,
    input logic out_err,
    input logic collision
);

    a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r5_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    a_r6_err_only_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_last);

    a_r7_quiet_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(crs_dv, 1) && !$past(crs_dv, 2) && !$past(crs_dv, 3) && !$past(crs_dv, 4))
        |-> !out_valid);

    a_r9_col_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !collision);

    a_r1_col_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(crs_dv, 2) |-> !collision);

endmodule

bind rmii_rx_mac rmii_rx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .crs_dv    (crs_dv),
    .tx_en     (tx_en),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_err   (out_err),
    .collision (collision)
);

// File: tb/tb_rmii_rx_mac.sv
module tb_rmii_rx_mac;

    localparam int CLK_PERIOD = 20;
    localparam int MAX_BEATS  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crs_dv = 1'b0;
    logic [1:0] rxd = 2'b00;
    logic       rx_er = 1'b0;
    logic       tx_en = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_err;
    logic       collision;

    int checks = 0;
    int errors = 0;

    logic [7:0] got_data [MAX_BEATS];
    logic       got_last [MAX_BEATS];
    logic       got_err  [MAX_BEATS];
    int         got_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmii_rx_mac dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .crs_dv    (crs_dv),
        .rxd       (rxd),
        .rx_er     (rx_er),
        .tx_en     (tx_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_err   (out_err),
        .collision (collision)
    );

    // Capture the output stream away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && got_n < MAX_BEATS) begin
            got_data[got_n] = out_data;
            got_last[got_n] = out_last;
            got_err[got_n]  = out_err;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one di-bit period, starting and ending on a falling edge
    task automatic dib(input logic c, input logic [1:0] d, input logic e);
        crs_dv = c;
        rxd    = d;
        rx_er  = e;
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int seed, input int i);
        return 8'((seed + i * 53 + (i * i) * 7) & 8'hff);
    endfunction

    // One frame: leading zeros, preamble, SFD, payload, optional tail, idle gap.
    // errpos = payload di-bit index with rx_er high (-1 none); pre_er puts rx_er in the preamble.
    task automatic run_frame(input int nz, input int npre, input int nb, input int extra,
                             input int errpos, input bit pre_er, input int seed,
                             input string req);
        int ndib;
        int exp_n;
        bit exp_e;
        logic [1:0] d;
        got_n = 0;
        for (int i = 0; i < nz; i++) dib(1'b1, 2'b00, 1'b0);
        for (int i = 0; i < npre; i++) dib(1'b1, 2'b01, pre_er && (i == 0));
        dib(1'b1, 2'b11, 1'b0);
        ndib = nb * 4 + extra;
        for (int k = 0; k < ndib; k++) begin
            if (k < nb * 4) begin
                d = exp_byte(seed, k / 4) >> (2 * (k % 4));
            end else begin
                d = 2'((k * 3 + 1) & 3);
            end
            dib(1'b1, d, (k == errpos));
        end
        for (int i = 0; i < 8; i++) dib(1'b0, 2'b00, 1'b0);
        exp_n = nb;
        exp_e = (errpos >= 0 && errpos < ndib) || (extra != 0);
        chk(got_n == exp_n, req, "beat count", got_n, exp_n);
        if (got_n == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                chk(got_data[i] == exp_byte(seed, i), req, "byte value",
                    int'(got_data[i]), int'(exp_byte(seed, i)));
                chk(got_last[i] == (i == exp_n - 1), "R5", "last flag",
                    int'(got_last[i]), int'(i == exp_n - 1));
                chk(got_err[i] == ((i == exp_n - 1) && exp_e), req, "error flag",
                    int'(got_err[i]), int'((i == exp_n - 1) && exp_e));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last && !out_err && !collision, "R11", "outputs in reset",
            int'({out_valid, out_last, out_err, collision}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !collision, "R11", "outputs after reset",
            int'({out_valid, collision}), 0);

        // R1 / R9: collision latency and gating
        tx_en = 1'b1;
        crs_dv = 1'b1;
        @(negedge clk);
        chk(collision == 1'b0, "R1", "collision after one edge", int'(collision), 0);
        @(negedge clk);
        chk(collision == 1'b1, "R1", "collision after two edges", int'(collision), 1);
        tx_en = 1'b0;
        #1;
        chk(collision == 1'b0, "R9", "collision with tx off", int'(collision), 0);
        tx_en = 1'b1;
        crs_dv = 1'b0;
        repeat (2) @(negedge clk);
        chk(collision == 1'b0, "R9", "collision after carrier drop", int'(collision), 0);
        tx_en = 1'b0;
        repeat (4) @(negedge clk);

        // R2 / R4: sweep leading zeros, preamble length and payload length
        for (int nz = 0; nz < 4; nz++) begin
            for (int nb = 1; nb <= 5; nb++) begin
                run_frame(nz, 1 + ((nz * 5 + nb) % 7), nb, 0, -1, 1'b0, nz * 17 + nb, "R4");
            end
        end
        run_frame(3, 7, 2, 0, -1, 1'b0, 201, "R2");

        // R6: error pulse at every payload di-bit of a 3-byte frame
        for (int p = 0; p < 12; p++) begin
            run_frame(1, 3, 3, 0, p, 1'b0, 90 + p, "R6");
        end

        // R8 / R10: truncated frames
        for (int nb = 0; nb <= 2; nb++) begin
            for (int ex = 1; ex <= 3; ex++) begin
                run_frame(2, 2, nb, ex, -1, 1'b0, 40 + nb * 3 + ex, (nb == 0) ? "R10" : "R8");
            end
        end
        run_frame(0, 4, 0, 0, -1, 1'b0, 7, "R10");

        // R7: rx_er inside the preamble is cleared at SFD
        run_frame(1, 5, 2, 0, -1, 1'b1, 120, "R7");

        // R7: noise on rxd / rx_er without carrier
        got_n = 0;
        for (int i = 0; i < 6; i++) dib(1'b0, 2'(i | 1), 1'b1);
        for (int i = 0; i < 4; i++) dib(1'b0, 2'b00, 1'b0);
        chk(got_n == 0, "R7", "beats from noise", got_n, 0);
        run_frame(0, 2, 3, 0, -1, 1'b0, 77, "R7");

        // R3: malformed preambles are discarded
        got_n = 0;
        dib(1'b1, 2'b00, 1'b0);
        dib(1'b1, 2'b01, 1'b0);
        dib(1'b1, 2'b10, 1'b0);
        dib(1'b1, 2'b11, 1'b0);
        for (int i = 0; i < 8; i++) dib(1'b1, 2'(i), 1'b0);
        for (int i = 0; i < 8; i++) dib(1'b0, 2'b00, 1'b0);
        chk(got_n == 0, "R3", "beats after bad preamble", got_n, 0);
        got_n = 0;
        dib(1'b1, 2'b11, 1'b0);
        for (int i = 0; i < 8; i++) dib(1'b1, 2'b01, 1'b0);
        for (int i = 0; i < 8; i++) dib(1'b0, 2'b00, 1'b0);
        chk(got_n == 0, "R3", "beats after SFD without preamble", got_n, 0);
        run_frame(0, 1, 1, 0, -1, 1'b0, 250, "R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule